// File: doc/BRIEF.md
# Out-of-Order Command Buffer Fill Tracker

This block snoops 32-bit writes that a producer makes into a command buffer held in memory and works out how many words at the front of that buffer have become contiguous and ready for the consumer. Producers may write words out of order. The tracker keeps a low mark and a high mark, which are word positions inside the buffer, and a count of the holes between them. Words are released into the depth count only after every gap below the highest written word has been filled.

Software programs the buffer window through a small configuration port. One register holds the base page. A second register holds the size in pages and the enable bit. The tracker has three named states. `TRK_OFF` means tracking is inactive. `TRK_LINEAR` means no holes are pending. `TRK_GAPPED` means holes are pending.

The transitions are:
- *arm*: `TRK_OFF` to `TRK_LINEAR` on the first clock edge with enable set.
- *open-gap*: `TRK_LINEAR` to `TRK_GAPPED` on a write that lands more than one word past the high mark.
- *close-gap*: `TRK_GAPPED` to `TRK_LINEAR` on the write that fills the last hole.
- *drop*: any state to `TRK_OFF` on any configuration write.

The consumer pulses `pop` once for each word it takes. `fifo_depth` reports words released minus words popped.

Top module: `cmdq_fill_tracker`

## Requirements
- R1: The base byte address is configuration bits [11:0] (written with `cfg_sel`=0) shifted left by 12. The size is bits [7:0] of the control register (`cfg_sel`=1). The window end is base + ((size+1) << 12). Only snoops with base ≤ address < end are tracked; any other snoop changes neither depth nor error.
- R2: Reset, and every configuration write, clear the depth, the error flag, both marks and the hole count, and enter `TRK_OFF`. When control bit 8 (enable) is set, the first snoop that counts is the one sampled on the second clock edge after the configuration write.
- R3: While enable is 0, snoops have no effect.
- R4: With no holes pending, a write to the word just after the high mark sets both marks to that word, and depth rises by one on the same clock edge.
- R5: With no holes pending, a write to the base word restarts tracking with both marks at the base word, and depth rises by one.
- R6: With no holes pending, a write more than one word past the high mark moves the high mark there and leaves depth unchanged. The hole count becomes the number of words strictly between the low mark and that address.
- R7: While holes are pending, a write strictly between the marks decrements the hole count without changing depth. The write that takes the count to zero adds (high − low) words to depth at once, and moves the low mark up to the high mark.
- R8: While holes are pending, a write below the low mark is ignored and sets `order_err`. The flag stays set until reset or a configuration write.
- R9: Depth equals words released minus words popped. A `pop` while depth is zero is ignored.
- R10: With no holes pending, a rewrite at or below the high mark (other than the base word) is ignored. While holes are pending, a write at the low mark, or at or above the high mark, is ignored and leaves `order_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| cfg_wdata | input | CFG_W (12) | Configuration write data |
| snoop_valid | input | 1 | A 32-bit write to memory is observed this cycle |
| snoop_addr | input | ADDR_W (32) | Byte address of the observed write |
| pop | input | 1 | Consumer takes one word |
| fifo_depth | output | DEPTH_W (32) | Words ready for the consumer |
| order_err | output | 1 | Sticky flag for a write below the low mark while holes are pending |

## Verification
Strictly sequential fills show that each word is released on the edge it is written. A far-ahead write followed by fills in descending order shows that nothing is released until the final fill, and that the final fill releases the whole span at once. Writes at the base word, at the marks, below the low mark and just outside either end of the window separate the restart, ignore, error and range rules from one another. A long stream of random in-window writes mixed with random pops is compared cycle by cycle against a behavioural model, which exposes wrong hole arithmetic and pop-at-empty handling.

// File: rtl/cmdtrk_pkg.sv
package cmdtrk_pkg;

    typedef enum logic [1:0] {
        TRK_OFF    = 2'd0,
        TRK_LINEAR = 2'd1,
        TRK_GAPPED = 2'd2
    } trk_state_e;

    localparam logic CFG_SEL_BASE = 1'b0;
    localparam logic CFG_SEL_CTRL = 1'b1;

endpackage

// File: rtl/cmdtrk_window.sv
// Configuration registers and window decode: turns a snooped byte address
// into an in-window flag and a one-based word position.
module cmdtrk_window #(
    parameter int ADDR_W     = 32,
    parameter int BASE_W     = 12,
    parameter int SIZE_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int CFG_W      = 12,
    parameter int POS_W      = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              trk_en,
    output logic              in_win,
    output logic [POS_W-1:0]  word_pos
);
    import cmdtrk_pkg::*;

    localparam int XW = ADDR_W + 1;

    logic [BASE_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic              en_q;

    logic [XW-1:0] base_addr;
    logic [XW-1:0] end_addr;
    logic [XW-1:0] addr_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            en_q   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == CFG_SEL_BASE) begin
                base_q <= cfg_wdata[BASE_W-1:0];
            end else begin
                size_q <= cfg_wdata[SIZE_W-1:0];
                en_q   <= cfg_wdata[SIZE_W];
            end
        end
    end

    always_comb begin
        base_addr = XW'(base_q) << PAGE_SHIFT;
        end_addr  = base_addr + ((XW'(size_q) + XW'(1)) << PAGE_SHIFT);
        addr_x    = {1'b0, snoop_addr};
        in_win    = (addr_x >= base_addr) && (addr_x < end_addr);
        word_pos  = POS_W'((addr_x - base_addr) >> 2) + POS_W'(1);
    end

    assign trk_en = en_q;

endmodule

// File: rtl/cmdtrk_gapfsm.sv
// Mark and hole tracking state machine. Positions are one-based word
// indices; position 0 stands for "just below the base word".
module cmdtrk_gapfsm #(
    parameter int POS_W = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic                    hit,
    input  logic [POS_W-1:0]        pos,
    output cmdtrk_pkg::trk_state_e  state,
    output logic                    rel_valid,
    output logic [POS_W-1:0]        rel_cnt,
    output logic [POS_W-1:0]        holes,
    output logic                    order_err
);
    import cmdtrk_pkg::*;

    trk_state_e       state_q, state_d;
    logic [POS_W-1:0] low_q, low_d;
    logic [POS_W-1:0] high_q, high_d;
    logic [POS_W-1:0] holes_q, holes_d;
    logic             err_q, err_set;

    logic is_first, is_next, is_far, in_gap, is_below;

    always_comb begin
        is_first = (pos == POS_W'(1));
        is_next  = (pos == high_q + POS_W'(1));
        is_far   = (pos >  high_q + POS_W'(1));
        in_gap   = (pos >  low_q) && (pos < high_q);
        is_below = (pos <  low_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_OFF;
        else        state_q <= state_d;
    end

    // Transitions: arm, open-gap, close-gap, drop
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = TRK_OFF;
        end else begin
            unique case (state_q)
                TRK_OFF:    if (en) state_d = TRK_LINEAR;
                TRK_LINEAR: if (hit && !is_first && is_far) state_d = TRK_GAPPED;
                TRK_GAPPED: if (hit && in_gap && holes_q == POS_W'(1)) state_d = TRK_LINEAR;
                default:    state_d = TRK_OFF;
            endcase
        end
    end

    // Outputs and mark updates
    always_comb begin
        low_d     = low_q;
        high_d    = high_q;
        holes_d   = holes_q;
        rel_valid = 1'b0;
        rel_cnt   = '0;
        err_set   = 1'b0;
        if (clear) begin
            low_d   = '0;
            high_d  = '0;
            holes_d = '0;
        end else begin
            unique case (state_q)
                TRK_OFF: begin
                end
                TRK_LINEAR: begin
                    if (hit) begin
                        if (is_first || is_next) begin
                            low_d     = pos;
                            high_d    = pos;
                            rel_valid = 1'b1;
                            rel_cnt   = POS_W'(1);
                        end else if (is_far) begin
                            high_d  = pos;
                            holes_d = pos - low_q - POS_W'(1);
                        end
                    end
                end
                TRK_GAPPED: begin
                    if (hit) begin
                        if (in_gap) begin
                            holes_d = holes_q - POS_W'(1);
                            if (holes_q == POS_W'(1)) begin
                                rel_valid = 1'b1;
                                rel_cnt   = high_q - low_q;
                                low_d     = high_q;
                            end
                        end else if (is_below) begin
                            err_set = 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q   <= '0;
            high_q  <= '0;
            holes_q <= '0;
            err_q   <= 1'b0;
        end else begin
            low_q   <= low_d;
            high_q  <= high_d;
            holes_q <= holes_d;
            err_q   <= clear ? 1'b0 : (err_q | err_set);
        end
    end

    assign state     = state_q;
    assign holes     = holes_q;
    assign order_err = err_q;

endmodule

// File: rtl/cmdtrk_depth.sv
// Released-word and consumed-word counters; depth is their difference.
module cmdtrk_depth #(
    parameter int DEPTH_W = 32,
    parameter int POS_W   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               rel_valid,
    input  logic [POS_W-1:0]   rel_cnt,
    input  logic               pop,
    output logic [DEPTH_W-1:0] depth
);
    logic [DEPTH_W-1:0] wcnt_q;
    logic [DEPTH_W-1:0] rcnt_q;
    logic               avail;

    assign avail = (wcnt_q != rcnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else if (clear) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else begin
            if (rel_valid)    wcnt_q <= wcnt_q + DEPTH_W'(rel_cnt);
            if (pop && avail) rcnt_q <= rcnt_q + DEPTH_W'(1);
        end
    end

    assign depth = wcnt_q - rcnt_q;

endmodule

// File: rtl/cmdq_fill_tracker.sv
module cmdq_fill_tracker #(
    parameter int ADDR_W     = 32,
    parameter int BASE_W     = 12,
    parameter int SIZE_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int DEPTH_W    = 32,
    parameter int CFG_W      = (BASE_W > SIZE_W + 1) ? BASE_W : SIZE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               snoop_valid,
    input  logic [ADDR_W-1:0]  snoop_addr,
    input  logic               pop,
    output logic [DEPTH_W-1:0] fifo_depth,
    output logic               order_err
);
    import cmdtrk_pkg::*;

    localparam int POS_W = SIZE_W + PAGE_SHIFT - 2 + 1;

    logic             trk_en;
    logic             in_win;
    logic             hit;
    logic [POS_W-1:0] word_pos;
    logic             rel_valid;
    logic [POS_W-1:0] rel_cnt;
    logic [POS_W-1:0] trk_holes;
    trk_state_e       trk_state;

    cmdtrk_window #(
        .ADDR_W(ADDR_W), .BASE_W(BASE_W), .SIZE_W(SIZE_W),
        .PAGE_SHIFT(PAGE_SHIFT), .CFG_W(CFG_W), .POS_W(POS_W)
    ) win_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .snoop_addr(snoop_addr),
        .trk_en(trk_en), .in_win(in_win), .word_pos(word_pos)
    );

    assign hit = snoop_valid && in_win;

    cmdtrk_gapfsm #(.POS_W(POS_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .clear(cfg_we), .en(trk_en),
        .hit(hit), .pos(word_pos), .state(trk_state),
        .rel_valid(rel_valid), .rel_cnt(rel_cnt),
        .holes(trk_holes), .order_err(order_err)
    );

    cmdtrk_depth #(.DEPTH_W(DEPTH_W), .POS_W(POS_W)) depth_i (
        .clk(clk), .rst_n(rst_n), .clear(cfg_we),
        .rel_valid(rel_valid), .rel_cnt(rel_cnt),
        .pop(pop), .depth(fifo_depth)
    );

endmodule

// File: rtl/cmdq_fill_tracker_sva.sv
module cmdq_fill_tracker_sva #(
    parameter int DEPTH_W = 32,
    parameter int POS_W   = 19
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   snoop_valid,
    input logic                   pop,
    input logic [DEPTH_W-1:0]     fifo_depth,
    input logic                   order_err,
    input cmdtrk_pkg::trk_state_e state,
    input logic [POS_W-1:0]       holes
);
    import cmdtrk_pkg::*;

    assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (fifo_depth == '0) && !order_err && (state == TRK_OFF));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (order_err && !cfg_we) |=> order_err);

    assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_depth == '0 && !snoop_valid && !cfg_we) |=> (fifo_depth == '0));

    assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_depth != '0 && !snoop_valid && !cfg_we)
            |=> (fifo_depth == $past(fifo_depth) - DEPTH_W'(1)));

    assert_gap_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_GAPPED && !pop && !cfg_we)
            |=> (state != TRK_GAPPED || $stable(fifo_depth)));

    assert_gap_has_holes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_GAPPED) |-> (holes != '0));

    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_OFF) |-> (holes == '0));

endmodule

bind cmdq_fill_tracker cmdq_fill_tracker_sva #(.DEPTH_W(DEPTH_W), .POS_W(POS_W)) sva_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .snoop_valid(snoop_valid),
    .pop(pop), .fifo_depth(fifo_depth), .order_err(order_err),
    .state(trk_state), .holes(trk_holes)
);

// File: tb/cmdq_fill_tracker_tb_top.sv
`timescale 1ns/1ps
module cmdq_fill_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        pop = 1'b0;
    logic [31:0] fifo_depth;
    logic        order_err;

    always #2.5 clk = ~clk;

    cmdq_fill_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .pop(pop),
        .fifo_depth(fifo_depth), .order_err(order_err)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R2";

    // Behavioural reference model
    longint m_base = 0, m_size = 0;
    bit     m_en = 0;
    int     m_st = 0;            // 0 idle, 1 no holes, 2 holes pending
    longint m_lo = 0, m_hi = 0, m_holes = 0;
    longint m_wd = 0, m_rd = 0;
    bit     m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_size = 0; m_en = 0; m_st = 0;
            m_lo = 0; m_hi = 0; m_holes = 0; m_wd = 0; m_rd = 0; m_err = 0;
        end else if (cfg_we) begin
            if (cfg_sel == 1'b0) m_base = cfg_wdata;
            else begin
                m_size = cfg_wdata & 12'hFF;
                m_en   = cfg_wdata[8];
            end
            m_st = 0; m_lo = 0; m_hi = 0; m_holes = 0;
            m_wd = 0; m_rd = 0; m_err = 0;
        end else begin
            bit can_pop;
            can_pop = (m_wd != m_rd);
            if (m_st == 0) begin
                if (m_en) m_st = 1;
            end else if (snoop_valid) begin
                longint lo_a, hi_a, a, p;
                lo_a = m_base * 4096;
                hi_a = lo_a + (m_size + 1) * 4096;
                a    = snoop_addr;
                if (a >= lo_a && a < hi_a) begin
                    p = (a - lo_a) / 4 + 1;
                    if (m_st == 1) begin
                        if (p == 1 || p == m_hi + 1) begin
                            m_lo = p; m_hi = p; m_wd++;
                        end else if (p > m_hi + 1) begin
                            m_holes = p - m_lo - 1; m_hi = p; m_st = 2;
                        end
                    end else begin
                        if (p > m_lo && p < m_hi) begin
                            m_holes--;
                            if (m_holes == 0) begin
                                m_wd += m_hi - m_lo; m_lo = m_hi; m_st = 1;
                            end
                        end else if (p < m_lo) begin
                            m_err = 1;
                        end
                    end
                end
            end
            if (pop && can_pop) m_rd++;
        end
    end

    // Comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [31:0] exp_d;
            exp_d = 32'(m_wd - m_rd);
            n_chk++;
            if (fifo_depth !== exp_d || order_err !== m_err) begin
                n_fail++;
                $display("FAIL %s: depth=%0d err=%0b expected depth=%0d err=%0b at %0t",
                         cur_req, fifo_depth, order_err, exp_d, m_err, $time);
            end
        end
    end

    task automatic cfg_write(input bit sel, input logic [11:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R2: reset state
        cur_req = "R2"; idle(3);

        // R3: disabled window ignores snoops
        cur_req = "R3";
        cfg_write(1'b1, 12'h001);
        cfg_write(1'b0, 12'h010);
        idle(2);
        snoop(32'h0001_0000); snoop(32'h0001_0004); idle(2);

        // R2: enable; arming takes one more edge
        cur_req = "R2";
        cfg_write(1'b1, 12'h101);
        idle(2);

        // R4: sequential fills
        cur_req = "R4";
        snoop(32'h0001_0000); snoop(32'h0001_0004); snoop(32'h0001_0008);

        // R10: rewrite below high mark is ignored
        cur_req = "R10";
        snoop(32'h0001_0004);

        // R9: pops, including pops at empty
        cur_req = "R9";
        do_pop(); do_pop(); do_pop(); do_pop(); do_pop(); idle(1);

        // R5: write to base restarts tracking
        cur_req = "R5";
        snoop(32'h0001_0000); snoop(32'h0001_0004);

        // R6: far write opens three holes
        cur_req = "R6";
        snoop(32'h0001_0014);

        // R10: writes at high mark and at low mark while gapped
        cur_req = "R10";
        snoop(32'h0001_0014); snoop(32'h0001_0004);

        // R7: fill holes from the top down
        cur_req = "R7";
        snoop(32'h0001_0010); snoop(32'h0001_000C);

        // R8: write below the low mark while gapped
        cur_req = "R8";
        snoop(32'h0001_0000);

        // R7: final fill releases the span
        cur_req = "R7";
        snoop(32'h0001_0008);

        // R8: error stays set
        cur_req = "R8"; idle(3);

        // R1: window edges
        cur_req = "R1";
        snoop(32'h0000_FFFC); snoop(32'h0001_2000); snoop(32'h0002_0000);
        snoop(32'h0001_0018);

        // R1: largest base and size
        cfg_write(1'b0, 12'hFFF);
        cfg_write(1'b1, 12'h1FF);
        idle(2);
        snoop(32'h00FF_F000); snoop(32'h010F_EFFC); snoop(32'h010F_F000);
        snoop(32'h00FF_EFFC);

        // R2: config write clears everything
        cur_req = "R2";
        cfg_write(1'b0, 12'h010);
        cfg_write(1'b1, 12'h101);
        idle(2);

        // Random stream in a small region with pops (R7, R9)
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            snoop_valid = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 19) == 0)
                snoop_addr = 32'h0001_2000 + 32'($urandom_range(0, 7)) * 4;
            else
                snoop_addr = 32'h0001_0000 + 32'($urandom_range(0, 39)) * 4;
            pop = ($urandom_range(0, 9) < 3);
        end
        @(negedge clk); snoop_valid = 1'b0; pop = 1'b0;
        idle(3);
        finish_run();
    end

endmodule